// File: doc/BRIEF.md
# Packed Byte/Word Media ALU

This unit is a two-stage execution pipe for packed media arithmetic on 64-bit integer operands. Each operand is viewed either as eight independent byte lanes or as four independent 16-bit word lanes. The unit offers lane-wise minimum and maximum in signed and unsigned forms. It also has a reduction that adds up the absolute byte differences of the two operands, which is the basic error metric for pixel blocks. Four width-changing moves convert between words or longwords and bytes.

An operation is presented as an opcode with operands A and B, qualified by `in_valid`. Its result appears on `out_data`, qualified by `out_valid`, exactly two clock edges later. The pipe takes a new operation on every cycle and has no back-pressure. There is no ready signal, so the consumer must accept each result in the cycle in which `out_valid` is high.

Top module: `pmx_media_alu`

## Requirements
- R1: Opcodes 0 to 3 (0 unsigned min, 1 signed min, 2 unsigned max, 3 signed max) act on eight independent byte lanes. Each result byte is the min or max of the same-position bytes of A and B, and the signed forms read each byte as two's complement.
- R2: Opcodes 4 to 7 (4 unsigned min, 5 signed min, 6 unsigned max, 7 signed max) do the same on four independent 16-bit lanes.
- R3: Opcode 8 returns the sum of |A byte i − B byte i| over all eight byte lanes, zero-extended to 64 bits. Bits 63 to 11 are always zero, and the largest value is 2040.
- R4: Opcode 9 (pack words to bytes) writes the low byte of word i of B to result byte i for i = 0..3, and clears bytes 4 to 7.
- R5: Opcode 10 (unpack bytes to words) writes byte i of B (i = 0..3) to the low byte of result word i, with the high byte of each word zero.
- R6: Opcode 11 (pack longwords to bytes) writes the low byte of longword 0 of B to result byte 0 and the low byte of longword 1 to result byte 1. All other bytes are zero.
- R7: Opcode 12 (unpack bytes to longwords) zero-extends byte 0 of B into longword 0 and byte 1 of B into longword 1.
- R8: Opcodes 9 to 12 read only operand B, and the value of A has no effect on their result.
- R9: `out_valid` is high exactly two rising edges after `in_valid` was sampled high. A new operation may be issued on every cycle, and results come out in issue order.
- R10: Opcodes 13 to 15 produce an all-zero result.
- R11: While `rst_n` is low, and on the first edges after it rises with no input, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Result |

## Verification
The hardest condition to reach is a full pipe. In that state, every stage holds a different opcode while a third operation waits at the input. An operation's stage-one lane results must then reach the output together with its own opcode, and must not be mixed with those of its neighbours. The vector table is therefore issued back to back, one entry per cycle. Adjacent entries alternate between byte, word, reduction and pack operations, and each result is compared two cycles after issue. Signed and unsigned versions run on the same lanes holding 0x80/0x7F and 0xFF/0x00, so that every signed/unsigned disagreement is exposed.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DATA_W = 64;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_MINUB  = 4'd0,
    OP_MINSB  = 4'd1,
    OP_MAXUB  = 4'd2,
    OP_MAXSB  = 4'd3,
    OP_MINUW  = 4'd4,
    OP_MINSW  = 4'd5,
    OP_MAXUW  = 4'd6,
    OP_MAXSW  = 4'd7,
    OP_SAD    = 4'd8,
    OP_PKWB   = 4'd9,
    OP_UNPKBW = 4'd10,
    OP_PKLB   = 4'd11,
    OP_UNPKBL = 4'd12
  } pmx_op_e;
endpackage

// File: rtl/pmx_lane_minmax.sv
module pmx_lane_minmax #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  input  logic              is_max,
  output logic [DATA_W-1:0] y
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0]   la, lb, ly;
    logic signed [LANE_W:0] ea, eb;
    logic                a_lt_b;

    always_comb begin
      la     = a[g*LANE_W +: LANE_W];
      lb     = b[g*LANE_W +: LANE_W];
      ea     = {is_signed & la[LANE_W-1], la};
      eb     = {is_signed & lb[LANE_W-1], lb};
      a_lt_b = ea < eb;
      if (is_max) ly = a_lt_b ? lb : la;
      else        ly = a_lt_b ? la : lb;
      AST_LANE_PICK: assert (ly == la || ly == lb); // R1
    end

    assign y[g*LANE_W +: LANE_W] = ly;
  end
endmodule

// File: rtl/pmx_absdiff.sv
module pmx_absdiff #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] d
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = a[g*LANE_W +: LANE_W];
    assign lb = b[g*LANE_W +: LANE_W];
    assign d[g*LANE_W +: LANE_W] = (la > lb) ? (la - lb) : (lb - la);
  end
endmodule

// File: rtl/pmx_pack.sv
module pmx_pack
  import pmx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  pmx_op_e           op,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int WORDS = DATA_W / 16;
  localparam int LONGS = DATA_W / 32;

  always_comb begin
    y = '0;
    case (op)
      OP_PKWB:
        for (int i = 0; i < WORDS; i++) y[8*i +: 8] = b[16*i +: 8];
      OP_UNPKBW:
        for (int i = 0; i < WORDS; i++) y[16*i +: 16] = {8'h00, b[8*i +: 8]};
      OP_PKLB:
        for (int i = 0; i < LONGS; i++) y[8*i +: 8] = b[32*i +: 8];
      OP_UNPKBL:
        for (int i = 0; i < LONGS; i++) y[32*i +: 32] = {24'h0, b[8*i +: 8]};
      default: y = '0;
    endcase
    if (op == OP_PKWB)
      AST_PK_UPPER_CLEAR: assert (y[DATA_W-1:DATA_W/2] == '0); // R4
  end
endmodule

// File: rtl/pmx_media_alu.sv
module pmx_media_alu
  import pmx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int LANES = DATA_W / BYTE_W;
  localparam int SUM_W = BYTE_W + $clog2(LANES);

  pmx_op_e           op0;
  logic [DATA_W-1:0] byte_y, word_y, ad_y, pk_y;

  assign op0 = pmx_op_e'(in_op);

  // op bit 0 selects signed, bit 1 selects max, bit 2 selects word lanes
  pmx_lane_minmax #(.DATA_W(DATA_W), .LANE_W(8)) u_mm_byte (
    .a(in_a), .b(in_b), .is_signed(in_op[0]), .is_max(in_op[1]), .y(byte_y));

  pmx_lane_minmax #(.DATA_W(DATA_W), .LANE_W(16)) u_mm_word (
    .a(in_a), .b(in_b), .is_signed(in_op[0]), .is_max(in_op[1]), .y(word_y));

  pmx_absdiff #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_absdiff (
    .a(in_a), .b(in_b), .d(ad_y));

  pmx_pack #(.DATA_W(DATA_W)) u_pack (.op(op0), .b(in_b), .y(pk_y));

  // stage 1 registers
  logic              v1;
  pmx_op_e           op1;
  logic [DATA_W-1:0] mm1, ad1, pk1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;
  end

  always_ff @(posedge clk) begin
    op1 <= op0;
    mm1 <= in_op[2] ? word_y : byte_y;
    ad1 <= ad_y;
    pk1 <= pk_y;
  end

  // stage 2: reduction and result select
  logic [SUM_W-1:0]  sad_sum;
  logic [DATA_W-1:0] res2;
  pmx_op_e           op2;

  always_comb begin
    sad_sum = '0;
    for (int i = 0; i < LANES; i++)
      sad_sum = sad_sum + SUM_W'(ad1[BYTE_W*i +: BYTE_W]);
  end

  always_comb begin
    case (op1)
      OP_MINUB, OP_MINSB, OP_MAXUB, OP_MAXSB,
      OP_MINUW, OP_MINSW, OP_MAXUW, OP_MAXSW: res2 = mm1;
      OP_SAD:                                 res2 = DATA_W'(sad_sum);
      OP_PKWB, OP_UNPKBW, OP_PKLB, OP_UNPKBL: res2 = pk1;
      default:                                res2 = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v1;
  end

  always_ff @(posedge clk) begin
    out_data <= res2;
    op2      <= op1;
  end

  AST_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid); // R9
  AST_SAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op2 == OP_SAD) |-> (out_data[DATA_W-1:SUM_W] == '0)); // R3
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && 4'(op2) > 4'd12) |-> (out_data == '0)); // R10
endmodule

// File: tb/pmx_media_alu_tb.sv
module pmx_media_alu_tb_top;
  localparam int N = 24;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  rq;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam logic [63:0] VA = 64'h807F01FF1000FE05;
  localparam logic [63:0] VB = 64'h7F8002000F01FF05;
  localparam logic [63:0] PB = 64'h1122334455667788;

  localparam vec_t VT [N] = '{
    '{4'd0,  4'd1,  VA, VB, 64'h7F7F01000F00FE05},  // R1 unsigned byte min
    '{4'd1,  4'd1,  VA, VB, 64'h808001FF0F00FE05},  // R1 signed byte min
    '{4'd2,  4'd1,  VA, VB, 64'h808002FF1001FF05},  // R1 unsigned byte max
    '{4'd3,  4'd1,  VA, VB, 64'h7F7F02001001FF05},  // R1 signed byte max
    '{4'd4,  4'd2,  VA, VB, 64'h7F8001FF0F01FE05},  // R2 unsigned word min
    '{4'd5,  4'd2,  VA, VB, 64'h807F01FF0F01FE05},  // R2 signed word min
    '{4'd6,  4'd2,  VA, VB, 64'h807F02001000FF05},  // R2 unsigned word max
    '{4'd7,  4'd2,  VA, VB, 64'h7F8002001000FF05},  // R2 signed word max
    '{4'd8,  4'd3,  VA, VB, 64'd261},               // R3 mixed lanes
    '{4'd8,  4'd3,  {64{1'b1}}, 64'd0, 64'd2040},   // R3 maximum
    '{4'd8,  4'd3,  VB, VA, 64'd261},               // R3 swapped operands
    '{4'd8,  4'd3,  PB, PB, 64'd0},                 // R3 equal operands
    '{4'd9,  4'd4,  VA, PB, 64'h0000000022446688},  // R4
    '{4'd10, 4'd5,  VA, PB, 64'h0055006600770088},  // R5
    '{4'd11, 4'd6,  VA, PB, 64'h0000000000004488},  // R6
    '{4'd12, 4'd7,  VA, PB, 64'h0000007700000088},  // R7
    '{4'd9,  4'd8,  {64{1'b1}}, PB, 64'h0000000022446688}, // R8 A ignored
    '{4'd10, 4'd8,  64'd0,      PB, 64'h0055006600770088}, // R8
    '{4'd11, 4'd8,  VB,         PB, 64'h0000000000004488}, // R8
    '{4'd12, 4'd8,  {64{1'b1}}, PB, 64'h0000007700000088}, // R8
    '{4'd13, 4'd10, VA, VB, 64'd0},                 // R10
    '{4'd14, 4'd10, VA, VB, 64'd0},                 // R10
    '{4'd15, 4'd10, PB, PB, 64'd0},                 // R10
    '{4'd3,  4'd1,  64'h8000800080008000, 64'h7FFF7FFF7FFF7FFF,
                    64'h7F007F007F007F00}           // R1 byte view of word values
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pmx_media_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data));

  task automatic check(input string rq, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R11: quiet during reset
    repeat (3) @(negedge clk);
    check("R11 valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 valid after reset", {63'd0, out_valid}, 64'd0);

    // streamed table: entry k driven at negedge k, result at negedge k+2 (R9)
    for (int k = 0; k < N + 2; k++) begin
      if (k >= 2) begin
        check($sformatf("R9 valid for entry %0d", k - 2), {63'd0, out_valid}, 64'd1);
        check($sformatf("R%0d entry %0d", VT[k-2].rq, k - 2), out_data, VT[k-2].exp);
      end
      if (k < N) begin
        in_valid = 1'b1;
        in_op    = VT[k].op;
        in_a     = VT[k].a;
        in_b     = VT[k].b;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    @(negedge clk);
    check("R9 drains", {63'd0, out_valid}, 64'd0);

    // R9: single pulse latency
    in_valid = 1'b1;
    in_op    = 4'd8;
    in_a     = {64{1'b1}};
    in_b     = '0;
    @(negedge clk);
    in_valid = 1'b0;
    in_a     = '0;
    check("R9 not after one edge", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R9 valid after two edges", {63'd0, out_valid}, 64'd1);
    check("R3 pulse sum", out_data, 64'd2040);
    @(negedge clk);
    check("R9 single cycle valid", {63'd0, out_valid}, 64'd0);

    // R11: reset in mid-flight clears valid
    in_valid = 1'b1;
    in_op    = 4'd0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    check("R11 reset flushes", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 quiet after flush", {63'd0, out_valid}, 64'd0);

    finish_run();
  end
endmodule